// File: doc/BRIEF.md
# Input Tree Associative Matcher

This block keeps the input histories of code regions as a set of multiway trees inside a small associative table, and it searches that table to decide whether a region can be skipped. Every table entry records the index of its parent entry, the input value that node stands for, and the address of the input that must be read next. A tree's root entry carries the region's start PC as its value. A node's value determines which child, and so which next address, follows it. Two stored histories can therefore read different addresses after the point where their values diverge.

A search begins by looking up the root that matches the PC. After each match, the matcher fetches the current value at the matched node's next address through a request/acknowledge port. It then looks for the entry whose parent is the node just matched and whose value equals the fetched value. The search ends in one of three ways: a hit at a leaf, whose index is used to retrieve stored outputs; a miss that names the last node matched; or a miss at the root.

A store streams one recorded input list, root first. It follows the part of the path that already exists and appends only the missing tail, taking new entries from a bump pointer. If the tail does not fit in the free space, nothing is written.

Top module: `input_tree_matcher`

## Requirements
- R1: A search whose PC has no root entry ends with srchDone=1, srchHit=0 and srchRootMiss=1, and it issues no fetch.
- R2: A search reports srchHit=1 only when every input along one stored path matches. srchNode then gives that path's leaf index. A root that is itself a leaf hits without any fetch.
- R3: When the root matches but some later input finds no child with equal value, the search ends with srchHit=0, srchRootMiss=0 and srchNode equal to the index of the last node matched.
- R4: Each fetchAddr equals the next-address field of the node matched most recently, so a different input value can lead to a different next address. fetchReq and fetchAddr stay unchanged until fetchVld is seen.
- R5: An input whose next-address entry is flagged memory-sourced takes exactly one more cycle to compare than a register-sourced input.
- R6: A store allocates new entries at consecutive indices taken from a free pointer that starts at 0 after reset. It reuses every leading node that already matches in parent and value, and storeLeaf gives the index of the list's final node.
- R7: Storing a list that is already fully present allocates no entry, reports storeOk=1, and reports the existing leaf as storeLeaf.
- R8: A store whose unmatched tail needs more entries than remain free reports storeOk=0 and writes nothing, and the free pointer keeps its value. Every item of the list is still accepted.
- R9: After reset, busy, srchDone, storeDone, fetchReq and itemReady are all 0. Each done strobe lasts one cycle and coincides with busy=0.
- R10: A store whose tail needs exactly the number of free entries left succeeds and uses the last free entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| srchStart | input | 1 | Start a search; taken when idle, and takes priority over storeStart |
| srchPc | input | VAL_W | Start PC of the region being searched |
| storeStart | input | 1 | Start a store; taken when idle |
| storeLen | input | LEN_W | Number of list items, 1 to MAX_LEN |
| itemValid | input | 1 | A store item is present |
| itemValue | input | VAL_W | Item value; the first item is the PC |
| itemAddr | input | ADDR_W | Address of the input that follows this item |
| itemMem | input | 1 | 1 when that following input is memory-sourced |
| itemReady | output | 1 | Item accepted at this edge when itemValid=1 |
| fetchReq | output | 1 | Request for the current value at fetchAddr |
| fetchAddr | output | ADDR_W | Address to read |
| fetchMem | output | 1 | The requested input is memory-sourced |
| fetchVld | input | 1 | fetchData is valid |
| fetchData | input | VAL_W | Current value read at fetchAddr |
| busy | output | 1 | A search or store is in progress |
| srchDone | output | 1 | Search result strobe |
| srchHit | output | 1 | Every input matched |
| srchRootMiss | output | 1 | No root entry for the PC |
| srchNode | output | IDX_W | Leaf on a hit, last matched node on a non-root miss |
| storeDone | output | 1 | Store result strobe |
| storeOk | output | 1 | List inserted or already present |
| storeLeaf | output | IDX_W | Index of the list's final node when storeOk=1 |

## Verification
The bench builds two lists that share a prefix, then a third that branches to a memory-sourced address. This shows whether the prefix is reused: a design that duplicated shared nodes would return a later leaf index. It would also grow a second root that the search never reaches. Searches with a changed second value separate a root miss from a deep miss; a design that confused the two would report the wrong attach node. Fetch addresses are logged, which exposes a matcher that reads a fixed address instead of following the matched branch. Latency is compared between a path with a register-sourced input and one with a memory-sourced input to confirm the one-cycle penalty. Finally the table is filled to one free entry. An exact-fit store must succeed, and the overflowing stores that follow, both at the root and deep in the tree, must write nothing. A design that wrote a partial branch before aborting would make those paths hit, or would shift the indices that later stores receive.

// File: rtl/itm_pkg.sv
package itm_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOK,
    ST_FETCH,
    ST_HOLD,
    ST_WALK,
    ST_FILL,
    ST_DRAIN
  } itm_state_t;

  // control -> datapath
  typedef struct packed {
    logic ldSrch;      // key <= root, srchPc
    logic ldFetch;     // key <= child of curIdx, fetchData
    logic takeMatch;   // curIdx <= matchIdx
    logic ldStore;     // capture storeLen, clear item index
    logic itemAdv;     // step item index
    logic wrEntry;     // write item at free pointer
    logic keyFromItem; // compare key comes from the item stream
  } itm_strobe_t;

  // datapath -> control
  typedef struct packed {
    logic matchHit;
    logic matchLast;
    logic lastItem;
    logic fits;
    logic curMem;
    logic keyRoot;
  } itm_status_t;

endpackage

// File: rtl/itm_datapath.sv
module itm_datapath
  import itm_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int VAL_W   = 32,
  parameter int ADDR_W  = 32,
  parameter int MAX_LEN = 8,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int LEN_W  = $clog2(MAX_LEN + 1),
  localparam int CNT_W  = $clog2(ENTRIES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  itm_strobe_t       strb,
  output itm_status_t       stat,
  input  logic [VAL_W-1:0]  srchPc,
  input  logic [LEN_W-1:0]  storeLenIn,
  input  logic [VAL_W-1:0]  itemValue,
  input  logic [ADDR_W-1:0] itemAddr,
  input  logic              itemMem,
  input  logic [VAL_W-1:0]  fetchData,
  output logic [ADDR_W-1:0] fetchAddr,
  output logic              fetchMem,
  output logic [IDX_W-1:0]  curIdx
);

  // table storage
  logic [ENTRIES-1:0] tVld;
  logic [ENTRIES-1:0] tRoot;
  logic [ENTRIES-1:0] tLast;
  logic [ENTRIES-1:0] tMem;
  logic [IDX_W-1:0]   tPar  [ENTRIES];
  logic [VAL_W-1:0]   tVal  [ENTRIES];
  logic [ADDR_W-1:0]  tNext [ENTRIES];

  // search key and walk state
  logic               keyRoot;
  logic [IDX_W-1:0]   keyPar;
  logic [VAL_W-1:0]   keyVal;
  logic [LEN_W-1:0]   itemIdx;
  logic [LEN_W-1:0]   storeLen;
  logic [CNT_W-1:0]   freePtr;

  // compare key mux
  logic               cRoot;
  logic [IDX_W-1:0]   cPar;
  logic [VAL_W-1:0]   cVal;
  logic [ENTRIES-1:0] hitVec;
  logic [IDX_W-1:0]   matchIdx;
  logic [IDX_W-1:0]   wIdx;
  logic               itemFirst;
  logic               itemLast;

  assign itemFirst = (itemIdx == '0);
  assign itemLast  = (itemIdx == storeLen - LEN_W'(1));
  assign wIdx      = freePtr[IDX_W-1:0];

  always_comb begin
    if (strb.keyFromItem) begin
      cRoot = itemFirst;
      cPar  = curIdx;
      cVal  = itemValue;
    end else begin
      cRoot = keyRoot;
      cPar  = keyPar;
      cVal  = keyVal;
    end
  end

  // one comparator per entry
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign hitVec[g] = tVld[g] && (tVal[g] == cVal) &&
                       (cRoot ? tRoot[g] : (!tRoot[g] && (tPar[g] == cPar)));
  end

  always_comb begin
    matchIdx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (hitVec[i]) matchIdx = IDX_W'(i);
    end
  end

  always_comb begin
    stat.matchHit  = |hitVec;
    stat.matchLast = tLast[matchIdx];
    stat.lastItem  = itemLast;
    stat.fits      = (int'(storeLen) - int'(itemIdx)) <= (ENTRIES - int'(freePtr));
    stat.curMem    = tMem[curIdx];
    stat.keyRoot   = keyRoot;
  end

  assign fetchAddr = tNext[curIdx];
  assign fetchMem  = tMem[curIdx];

  // control registers
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tVld     <= '0;
      keyRoot  <= 1'b0;
      keyPar   <= '0;
      keyVal   <= '0;
      curIdx   <= '0;
      itemIdx  <= '0;
      storeLen <= '0;
      freePtr  <= '0;
    end else begin
      if (strb.ldSrch) begin
        keyRoot <= 1'b1;
        keyVal  <= srchPc;
      end
      if (strb.ldFetch) begin
        keyRoot <= 1'b0;
        keyPar  <= curIdx;
        keyVal  <= fetchData;
      end
      if (strb.ldStore) begin
        storeLen <= storeLenIn;
        itemIdx  <= '0;
      end
      if (strb.itemAdv) itemIdx <= itemIdx + LEN_W'(1);
      if (strb.takeMatch) curIdx <= matchIdx;
      if (strb.wrEntry) begin
        tVld[wIdx] <= 1'b1;
        curIdx     <= wIdx;
        freePtr    <= freePtr + CNT_W'(1);
      end
    end
  end

  // entry payload, no reset needed
  always_ff @(posedge clk) begin
    if (strb.wrEntry) begin
      tRoot[wIdx] <= itemFirst;
      tLast[wIdx] <= itemLast;
      tMem[wIdx]  <= itemMem;
      tPar[wIdx]  <= curIdx;
      tVal[wIdx]  <= itemValue;
      tNext[wIdx] <= itemAddr;
    end
  end

endmodule

// File: rtl/itm_ctrl.sv
module itm_ctrl
  import itm_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        srchStart,
  input  logic        storeStart,
  input  logic        itemValid,
  input  logic        fetchVld,
  input  itm_status_t stat,
  output itm_strobe_t strb,
  output logic        itemReady,
  output logic        fetchReq,
  output logic        busy,
  output logic        srchDone,
  output logic        srchHit,
  output logic        srchRootMiss,
  output logic        storeDone,
  output logic        storeOk
);

  itm_state_t state, stateNx;
  logic sDoneNx, sHitNx, sRootNx, tDoneNx, tOkNx;

  assign busy      = (state != ST_IDLE);
  assign fetchReq  = (state == ST_FETCH);
  assign itemReady = (state == ST_WALK) || (state == ST_FILL) || (state == ST_DRAIN);

  always_comb begin
    stateNx = state;
    strb    = '0;
    sDoneNx = 1'b0;
    sHitNx  = 1'b0;
    sRootNx = 1'b0;
    tDoneNx = 1'b0;
    tOkNx   = 1'b0;
    strb.keyFromItem = itemReady;
    unique case (state)
      ST_IDLE: begin
        if (srchStart) begin
          strb.ldSrch = 1'b1;
          stateNx     = ST_LOOK;
        end else if (storeStart) begin
          strb.ldStore = 1'b1;
          stateNx      = ST_WALK;
        end
      end
      ST_LOOK: begin
        if (stat.matchHit) begin
          strb.takeMatch = 1'b1;
          if (stat.matchLast) begin
            sDoneNx = 1'b1;
            sHitNx  = 1'b1;
            stateNx = ST_IDLE;
          end else begin
            stateNx = ST_FETCH;
          end
        end else begin
          sDoneNx = 1'b1;
          sRootNx = stat.keyRoot;
          stateNx = ST_IDLE;
        end
      end
      ST_FETCH: begin
        if (fetchVld) begin
          strb.ldFetch = 1'b1;
          stateNx      = stat.curMem ? ST_HOLD : ST_LOOK;
        end
      end
      ST_HOLD: stateNx = ST_LOOK;
      ST_WALK: begin
        if (itemValid) begin
          strb.itemAdv = 1'b1;
          if (stat.matchHit) begin
            strb.takeMatch = 1'b1;
            if (stat.lastItem) begin
              tDoneNx = 1'b1;
              tOkNx   = 1'b1;
              stateNx = ST_IDLE;
            end
          end else if (stat.fits) begin
            strb.wrEntry = 1'b1;
            if (stat.lastItem) begin
              tDoneNx = 1'b1;
              tOkNx   = 1'b1;
              stateNx = ST_IDLE;
            end else begin
              stateNx = ST_FILL;
            end
          end else begin
            if (stat.lastItem) begin
              tDoneNx = 1'b1;
              stateNx = ST_IDLE;
            end else begin
              stateNx = ST_DRAIN;
            end
          end
        end
      end
      ST_FILL: begin
        if (itemValid) begin
          strb.itemAdv = 1'b1;
          strb.wrEntry = 1'b1;
          if (stat.lastItem) begin
            tDoneNx = 1'b1;
            tOkNx   = 1'b1;
            stateNx = ST_IDLE;
          end
        end
      end
      ST_DRAIN: begin
        if (itemValid) begin
          strb.itemAdv = 1'b1;
          if (stat.lastItem) begin
            tDoneNx = 1'b1;
            stateNx = ST_IDLE;
          end
        end
      end
      default: stateNx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state        <= ST_IDLE;
      srchDone     <= 1'b0;
      srchHit      <= 1'b0;
      srchRootMiss <= 1'b0;
      storeDone    <= 1'b0;
      storeOk      <= 1'b0;
    end else begin
      state    <= stateNx;
      srchDone <= sDoneNx;
      storeDone <= tDoneNx;
      if (sDoneNx) begin
        srchHit      <= sHitNx;
        srchRootMiss <= sRootNx;
      end
      if (tDoneNx) storeOk <= tOkNx;
    end
  end

endmodule

// File: rtl/input_tree_matcher.sv
module input_tree_matcher
  import itm_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int VAL_W   = 32,
  parameter int ADDR_W  = 32,
  parameter int MAX_LEN = 8,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int LEN_W  = $clog2(MAX_LEN + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              srchStart,
  input  logic [VAL_W-1:0]  srchPc,
  input  logic              storeStart,
  input  logic [LEN_W-1:0]  storeLen,
  input  logic              itemValid,
  input  logic [VAL_W-1:0]  itemValue,
  input  logic [ADDR_W-1:0] itemAddr,
  input  logic              itemMem,
  output logic              itemReady,
  output logic              fetchReq,
  output logic [ADDR_W-1:0] fetchAddr,
  output logic              fetchMem,
  input  logic              fetchVld,
  input  logic [VAL_W-1:0]  fetchData,
  output logic              busy,
  output logic              srchDone,
  output logic              srchHit,
  output logic              srchRootMiss,
  output logic [IDX_W-1:0]  srchNode,
  output logic              storeDone,
  output logic              storeOk,
  output logic [IDX_W-1:0]  storeLeaf
);

  itm_strobe_t strb;
  itm_status_t stat;
  logic [IDX_W-1:0] curIdx;

  itm_ctrl ctrl_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .srchStart    (srchStart),
    .storeStart   (storeStart),
    .itemValid    (itemValid),
    .fetchVld     (fetchVld),
    .stat         (stat),
    .strb         (strb),
    .itemReady    (itemReady),
    .fetchReq     (fetchReq),
    .busy         (busy),
    .srchDone     (srchDone),
    .srchHit      (srchHit),
    .srchRootMiss (srchRootMiss),
    .storeDone    (storeDone),
    .storeOk      (storeOk)
  );

  itm_datapath #(
    .ENTRIES (ENTRIES),
    .VAL_W   (VAL_W),
    .ADDR_W  (ADDR_W),
    .MAX_LEN (MAX_LEN)
  ) dp_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .strb       (strb),
    .stat       (stat),
    .srchPc     (srchPc),
    .storeLenIn (storeLen),
    .itemValue  (itemValue),
    .itemAddr   (itemAddr),
    .itemMem    (itemMem),
    .fetchData  (fetchData),
    .fetchAddr  (fetchAddr),
    .fetchMem   (fetchMem),
    .curIdx     (curIdx)
  );

  assign srchNode  = curIdx;
  assign storeLeaf = curIdx;

endmodule

// File: rtl/itm_checker.sv
module itm_checker #(
  parameter int IDX_W  = 4,
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fetchReq,
  input logic              fetchVld,
  input logic [ADDR_W-1:0] fetchAddr,
  input logic              busy,
  input logic              itemReady,
  input logic              srchDone,
  input logic              srchHit,
  input logic              srchRootMiss,
  input logic              storeDone
);

  // R4: an outstanding fetch holds its address until acknowledged
  p_fetch_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fetchReq && !fetchVld |=> fetchReq && $stable(fetchAddr));

  // R2: a hit is never also a root miss
  p_hit_not_root_r2: assert property (@(posedge clk) disable iff (!rst_n)
    srchDone && srchHit |-> !srchRootMiss);

  // R9: result strobes appear only once the block is idle again
  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    srchDone || storeDone |-> !busy);

  // R9: search strobe lasts one cycle
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    srchDone |=> !srchDone);

  // R6: items are only accepted inside a store, never during a fetch
  p_ready_store_r6: assert property (@(posedge clk) disable iff (!rst_n)
    itemReady |-> busy && !fetchReq);

  // R9: the two result strobes never coincide
  p_one_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    srchDone |-> !storeDone);

endmodule

bind input_tree_matcher itm_checker #(.IDX_W(IDX_W), .ADDR_W(ADDR_W)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .fetchReq     (fetchReq),
  .fetchVld     (fetchVld),
  .fetchAddr    (fetchAddr),
  .busy         (busy),
  .itemReady    (itemReady),
  .srchDone     (srchDone),
  .srchHit      (srchHit),
  .srchRootMiss (srchRootMiss),
  .storeDone    (storeDone)
);

// File: tb/input_tree_matcher_tb_top.sv
`timescale 1ns/1ps
module input_tree_matcher_tb_top;

  localparam int ENTRIES = 16;
  localparam int MAX_LEN = 8;
  localparam int IDX_W   = $clog2(ENTRIES);
  localparam int LEN_W   = $clog2(MAX_LEN + 1);

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        srchStart = 1'b0;
  logic [31:0] srchPc = '0;
  logic        storeStart = 1'b0;
  logic [LEN_W-1:0] storeLen = '0;
  logic        itemValid = 1'b0;
  logic [31:0] itemValue = '0;
  logic [31:0] itemAddr = '0;
  logic        itemMem = 1'b0;
  logic        itemReady;
  logic        fetchReq;
  logic [31:0] fetchAddr;
  logic        fetchMem;
  logic        fetchVld = 1'b0;
  logic [31:0] fetchData = '0;
  logic        busy, srchDone, srchHit, srchRootMiss, storeDone, storeOk;
  logic [IDX_W-1:0] srchNode, storeLeaf;

  always #10 clk = ~clk;

  input_tree_matcher #(.ENTRIES(ENTRIES), .MAX_LEN(MAX_LEN)) dut_i (.*);

  typedef struct {
    bit    isStore;
    bit    hit;
    bit    rootMiss;
    int    node;
    string tag;
  } exp_t;

  exp_t expQ[$];
  int   addrLog[$];
  logic [31:0] memModel [16];
  logic [31:0] itV [MAX_LEN];
  logic [31:0] itA [MAX_LEN];
  logic        itM [MAX_LEN];
  int nChecks = 0;
  int nFails  = 0;
  int cyc = 0;
  int startCyc = 0;
  int lastLat = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // fetch responder: one-cycle acknowledge from the model memory
  initial begin
    forever begin
      @(negedge clk);
      if (fetchVld) fetchVld = 1'b0;
      else if (fetchReq) begin
        fetchVld  = 1'b1;
        fetchData = memModel[fetchAddr[3:0]];
        addrLog.push_back(int'(fetchAddr));
      end
    end
  end

  // monitor: pops expected results as the design produces them
  initial begin
    forever begin
      @(negedge clk);
      if (srchDone || storeDone) begin
        if (expQ.size() == 0) begin
          check(1'b0, "unexpected result strobe R9", 1, 0);
        end else begin
          exp_t e;
          e = expQ.pop_front();
          lastLat = cyc - startCyc;
          check(storeDone == e.isStore, {e.tag, " kind"}, int'(storeDone), int'(e.isStore));
          if (e.isStore) begin
            check(storeOk == e.hit, {e.tag, " storeOk"}, int'(storeOk), int'(e.hit));
            if (e.node >= 0)
              check(int'(storeLeaf) == e.node, {e.tag, " storeLeaf"}, int'(storeLeaf), e.node);
          end else begin
            check(srchHit == e.hit, {e.tag, " srchHit"}, int'(srchHit), int'(e.hit));
            check(srchRootMiss == e.rootMiss, {e.tag, " srchRootMiss"},
                  int'(srchRootMiss), int'(e.rootMiss));
            if (e.node >= 0)
              check(int'(srchNode) == e.node, {e.tag, " srchNode"}, int'(srchNode), e.node);
          end
        end
      end
    end
  end

  task automatic waitDrain();
    while (expQ.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic doSearch(input logic [31:0] pc, input bit eh, input bit er,
                          input int en, input string tag);
    exp_t e;
    e.isStore = 1'b0; e.hit = eh; e.rootMiss = er; e.node = en; e.tag = tag;
    expQ.push_back(e);
    addrLog.delete();
    @(negedge clk);
    srchStart = 1'b1;
    srchPc    = pc;
    startCyc  = cyc;
    @(negedge clk);
    srchStart = 1'b0;
    waitDrain();
  endtask

  task automatic doStore(input int len, input bit eok, input int eleaf, input string tag);
    exp_t e;
    bit   took;
    e.isStore = 1'b1; e.hit = eok; e.rootMiss = 1'b0; e.node = eleaf; e.tag = tag;
    expQ.push_back(e);
    @(negedge clk);
    storeStart = 1'b1;
    storeLen   = LEN_W'(len);
    @(negedge clk);
    storeStart = 1'b0;
    for (int k = 0; k < len; k++) begin
      itemValid = 1'b1;
      itemValue = itV[k];
      itemAddr  = itA[k];
      itemMem   = itM[k];
      do begin
        #1 took = itemReady;
        @(negedge clk);
      end while (!took);
    end
    itemValid = 1'b0;
    waitDrain();
  endtask

  task automatic setItem(input int k, input logic [31:0] v, input logic [31:0] a, input logic m);
    itV[k] = v; itA[k] = a; itM[k] = m;
  endtask

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog R9 actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  int latA, latC;

  initial begin
    for (int i = 0; i < 16; i++) memModel[i] = '0;
    repeat (3) @(negedge clk);
    // R9: reset state
    check(!busy && !srchDone && !storeDone, "R9 idle after reset", int'(busy), 0);
    check(!fetchReq && !itemReady, "R9 no requests after reset", int'(fetchReq), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: empty table, root miss
    doSearch(32'h100, 0, 1, -1, "R1 empty table");
    check(addrLog.size() == 0, "R1 no fetch on root miss", addrLog.size(), 0);

    // R6: first list 0x100 -> a1 -> a2, entries 0,1,2
    setItem(0, 32'h100, 32'd1, 0);
    setItem(1, 32'd10, 32'd2, 0);
    setItem(2, 32'd20, 32'd0, 0);
    doStore(3, 1, 2, "R6 first list");

    memModel[1] = 32'd10; memModel[2] = 32'd20;
    doSearch(32'h100, 1, 0, 2, "R2 full match");
    latA = lastLat;
    check(addrLog.size() == 2 && addrLog[0] == 1 && addrLog[1] == 2,
          "R4 addresses of first path", addrLog.size(), 2);

    doSearch(32'h200, 0, 1, -1, "R1 unknown pc");

    memModel[2] = 32'd21;
    doSearch(32'h100, 0, 0, 1, "R3 deep miss");

    // R6: shared prefix, only one new entry (3)
    setItem(2, 32'd21, 32'd0, 0);
    doStore(3, 1, 3, "R6 prefix reuse");
    doSearch(32'h100, 1, 0, 3, "R2 second leaf");
    memModel[2] = 32'd20;
    doSearch(32'h100, 1, 0, 2, "R2 first leaf still");

    // R7: duplicate list allocates nothing
    doStore(3, 1, 3, "R7 duplicate list");

    // branch to a memory-sourced address: entries 4,5 (index 4 proves R7)
    setItem(1, 32'd11, 32'd5, 1);
    setItem(2, 32'd50, 32'd0, 0);
    doStore(3, 1, 5, "R7 next index after duplicate");
    memModel[1] = 32'd11; memModel[5] = 32'd50;
    doSearch(32'h100, 1, 0, 5, "R4 branch hit");
    latC = lastLat;
    check(addrLog.size() == 2 && addrLog[1] == 5, "R4 value selects next address",
          (addrLog.size() == 2) ? addrLog[1] : -1, 5);
    check(latC - latA == 1, "R5 memory input extra cycle", latC - latA, 1);

    // R2: a root that is a leaf hits with no fetch (entry 6)
    setItem(0, 32'h300, 32'd0, 0);
    doStore(1, 1, 6, "R6 single item list");
    doSearch(32'h300, 1, 0, 6, "R2 leaf root");
    check(addrLog.size() == 0, "R2 leaf root no fetch", addrLog.size(), 0);

    // long list fills entries 7..14
    setItem(0, 32'h400, 32'd1, 0);
    for (int k = 1; k < 8; k++) setItem(k, 32'(k + 100), 32'd1, 0);
    doStore(8, 1, 14, "R6 long list");

    // R8: three needed, one free
    setItem(0, 32'h500, 32'd1, 0);
    setItem(1, 32'd1, 32'd2, 0);
    setItem(2, 32'd2, 32'd0, 0);
    doStore(3, 0, -1, "R8 abort at root");
    doSearch(32'h500, 0, 1, -1, "R8 aborted root absent");
    memModel[1] = 32'd10; memModel[2] = 32'd20;
    doSearch(32'h100, 1, 0, 2, "R8 old path intact");

    // R10: exact fit uses last entry 15
    setItem(0, 32'h100, 32'd1, 0);
    setItem(1, 32'd10, 32'd2, 0);
    setItem(2, 32'd22, 32'd0, 0);
    doStore(3, 1, 15, "R10 exact fit");
    memModel[2] = 32'd22;
    doSearch(32'h100, 1, 0, 15, "R10 exact fit searchable");

    // R8: table full, deep abort and root abort with drain
    setItem(1, 32'd11, 32'd5, 1);
    setItem(2, 32'd51, 32'd0, 0);
    doStore(3, 0, -1, "R8 abort deep");
    memModel[1] = 32'd11; memModel[5] = 32'd51;
    doSearch(32'h100, 0, 0, 4, "R8 deep branch not written");
    setItem(0, 32'h600, 32'd1, 0);
    setItem(1, 32'd7, 32'd0, 0);
    doStore(2, 0, -1, "R8 abort with drain");
    check(!busy, "R8 all items consumed", int'(busy), 0);
    doSearch(32'h600, 0, 1, -1, "R8 root not written");

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule